// File: doc/BRIEF.md
# Synthesizer Divider Chain With Test Monitor

This block is the digital divider chain that sits around a frequency synthesizer's oscillator. It is clocked by the oscillator-rate clock. A 9-bit feedback counter divides that clock by a programmed ratio M and produces the feedback signal for the phase comparator. A post divider, set by a 2-bit code to a power-of-two ratio, produces the output clock. That clock drives two complementary output pairs. A monitor multiplexer routes one of several internal nodes to a single test pin.

A master reset holds both dividers at zero and forces the pairs to a defined polarity. A bypass select takes the post divider's input from a reference clock instead of the oscillator. The reference is sampled and edge-detected in the oscillator domain. Ratio changes never cut a period short: a new M or code is taken up only when the counter it belongs to wraps. The phase comparator, loop filter and oscillator are not part of this block.

Top module: `synth_divchain`

## Requirements
- R1: With M of 2 or more, the feedback output repeats every M clocks and is high for floor(M/2) of them, starting high in the first clock after reset.
- R2: An M of 0 or 1 is treated as divide by 1: the feedback output follows the clock level.
- R3: The post divider code gives ratio 1 for 0, 2 for 1, 4 for 2 and 8 for 3. Ratios above 1 give exactly half the period high.
- R4: A new M is taken up only when the feedback counter is at its last count (M-1), so the current period completes.
- R5: A new divider code is taken up only when the post divider is at its last count.
- R6: While mr is high, fb_out and both true outputs are low, both inverted outputs are high, and both counters are cleared. On the first clock after release, an output with a ratio above 1 goes high.
- R7: Both pairs carry the same clock, and each inverted output is the complement of its true output.
- R8: When par_mode is low, test_sel selects test_out as follows: 0 gives low, 1 gives ser_din, 2 gives fb_out, and 3 gives the true output clock.
- R9: test_out is low whenever par_mode is high, whatever test_sel holds.
- R10: With bypass high, the post divider advances once per rising edge of ref_in, and ratio 1 passes the ref_in level. The feedback counter keeps running on the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| mr | input | 1 | Master reset, active high |
| bypass | input | 1 | Take the post divider input from ref_in |
| ref_in | input | 1 | Reference clock level |
| m_val | input | 9 | Feedback ratio M, plain binary |
| n_code | input | 2 | Post divider code |
| par_mode | input | 1 | Configuration is in parallel mode |
| test_sel | input | 2 | Monitor select |
| ser_din | input | 1 | Serial configuration data input |
| fb_out | output | 1 | Divided feedback signal |
| out0_p | output | 1 | Output pair 0, true |
| out0_n | output | 1 | Output pair 0, inverted |
| out1_p | output | 1 | Output pair 1, true |
| out1_n | output | 1 | Output pair 1, inverted |
| test_out | output | 1 | Monitor output |

## Verification
The hardest case to reach is a ratio change that lands mid-period. The new value must be ignored until the counter wraps, and this shows at the ports only as the length of the period in progress. The stimulus therefore changes M and the code a few clocks after a wrap, with the old and new ratios differing widely, so that an early take-up shifts the edges the model predicts. Bypass is driven with a slow reference that toggles every few clocks, so that the clocks without a reference edge must hold the divider still.

// File: rtl/synth_divchain.sv
module synth_divchain #(
  parameter int MW = 9,
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          mr,
  input  logic          bypass,
  input  logic          ref_in,
  input  logic [MW-1:0] m_val,
  input  logic [NW-1:0] n_code,
  input  logic          par_mode,
  input  logic [1:0]    test_sel,
  input  logic          ser_din,
  output logic          fb_out,
  output logic          out0_p,
  output logic          out0_n,
  output logic          out1_p,
  output logic          out1_n,
  output logic          test_out
);

  localparam int OCW = (1 << NW) - 1;

  function automatic logic [OCW:0] ratio_of(input logic [NW-1:0] c);
    return (OCW+1)'(1) << c;
  endfunction

  // feedback divider
  logic [MW-1:0] fcnt, fm, m_eff, nxt_fm, nxt_fcnt;
  logic          fq, f_tc;

  assign m_eff    = (m_val < MW'(2)) ? MW'(1) : m_val;
  assign f_tc     = (fcnt == fm - MW'(1));
  assign nxt_fm   = f_tc ? m_eff : fm;
  assign nxt_fcnt = f_tc ? '0 : fcnt + MW'(1);

  always_ff @(posedge clk) begin
    if (mr) begin
      fcnt <= '0;
      fm   <= m_eff;
      fq   <= (m_eff >> 1) != '0;
    end else begin
      fcnt <= nxt_fcnt;
      fm   <= nxt_fm;
      fq   <= nxt_fcnt < (nxt_fm >> 1);
    end
  end

  // post divider
  logic [OCW-1:0] ocnt, nxt_ocnt;
  logic [NW-1:0]  ocode, nxt_ocode;
  logic           oq, ref_d, tick, o_tc, oclk;

  assign tick      = bypass ? (ref_in & ~ref_d) : 1'b1;
  assign o_tc      = ({1'b0, ocnt} == ratio_of(ocode) - (OCW+1)'(1));
  assign nxt_ocode = o_tc ? n_code : ocode;
  assign nxt_ocnt  = o_tc ? '0 : ocnt + OCW'(1);

  always_ff @(posedge clk) begin
    ref_d <= ref_in;
    if (mr) begin
      ocnt  <= '0;
      ocode <= n_code;
      oq    <= n_code != '0;
    end else if (tick) begin
      ocnt  <= nxt_ocnt;
      ocode <= nxt_ocode;
      oq    <= {1'b0, nxt_ocnt} < (ratio_of(nxt_ocode) >> 1);
    end
  end

  // outputs
  assign fb_out = ~mr & ((fm == MW'(1)) ? clk : fq);
  assign oclk   = ~mr & ((ocode == '0) ? (bypass ? ref_in : clk) : oq);
  assign out0_p = oclk;
  assign out0_n = ~oclk;
  assign out1_p = oclk;
  assign out1_n = ~oclk;

  always_comb begin
    test_out = 1'b0;
    if (!par_mode) begin
      case (test_sel)
        2'd1:    test_out = ser_din;
        2'd2:    test_out = fb_out;
        2'd3:    test_out = oclk;
        default: test_out = 1'b0;
      endcase
    end
  end

endmodule

module synth_divchain_chk #(
  parameter int MW = 9,
  parameter int NW = 2
) (
  input logic          clk,
  input logic          mr,
  input logic          par_mode,
  input logic          fb_out,
  input logic          out0_p,
  input logic          out0_n,
  input logic          out1_p,
  input logic          out1_n,
  input logic          test_out,
  input logic [MW-1:0] fcnt,
  input logic [MW-1:0] fm,
  input logic [(1<<NW)-2:0] ocnt,
  input logic [NW-1:0] ocode
);
  localparam int OCW = (1 << NW) - 1;
  logic o_last;
  assign o_last = (int'(ocnt) == (1 << int'(ocode)) - 1);

  p_reset_levels_r6: assert property (@(posedge clk)
    mr |-> (!fb_out && !out0_p && !out1_p && out0_n && out1_n));

  p_pairs_agree_r7: assert property (@(posedge clk) disable iff (mr)
    (out0_p == out1_p) && (out0_n == out1_n) && (out0_p != out0_n));

  p_parallel_quiet_r9: assert property (@(posedge clk)
    par_mode |-> !test_out);

  p_fb_range_r1: assert property (@(posedge clk) disable iff (mr)
    fcnt < fm);

  p_m_hold_r4: assert property (@(posedge clk) disable iff (mr)
    (fcnt != fm - MW'(1)) |=> (fm == $past(fm)));

  p_code_hold_r5: assert property (@(posedge clk) disable iff (mr)
    !o_last |=> (ocode == $past(ocode)));
endmodule

bind synth_divchain synth_divchain_chk #(.MW(MW), .NW(NW)) u_chk (
  .clk(clk), .mr(mr), .par_mode(par_mode), .fb_out(fb_out),
  .out0_p(out0_p), .out0_n(out0_n), .out1_p(out1_p), .out1_n(out1_n),
  .test_out(test_out), .fcnt(fcnt), .fm(fm), .ocnt(ocnt), .ocode(ocode)
);

// File: tb/synth_divchain_test.sv
module synth_divchain_test;
  localparam int T = 10;

  logic       clk = 1'b0;
  logic       mr = 1'b1, bypass = 1'b0, ref_in = 1'b0;
  logic [8:0] m_val = 9'd5;
  logic [1:0] n_code = 2'd1;
  logic       par_mode = 1'b0;
  logic [1:0] test_sel = 2'd0;
  logic       ser_din = 1'b0;
  logic       fb_out, out0_p, out0_n, out1_p, out1_n, test_out;

  int vectors = 0, errors = 0;
  string req = "R6";

  // behavioural reference state
  int fc = 0, fmv = 5, oc = 0, ocd = 1, rprev = 0;
  bit fq = 1'b1, oq = 1'b1;

  always #(T/2) clk = ~clk;

  synth_divchain uut (
    .clk(clk), .mr(mr), .bypass(bypass), .ref_in(ref_in), .m_val(m_val),
    .n_code(n_code), .par_mode(par_mode), .test_sel(test_sel), .ser_din(ser_din),
    .fb_out(fb_out), .out0_p(out0_p), .out0_n(out0_n), .out1_p(out1_p),
    .out1_n(out1_n), .test_out(test_out)
  );

  function automatic int eff_m(input int m);
    return (m < 2) ? 1 : m;
  endfunction

  task automatic chk(input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit efb, eout, etest;
    efb  = mr ? 1'b0 : ((fmv == 1) ? 1'b0 : fq);
    eout = mr ? 1'b0 : ((ocd == 0) ? (bypass ? ref_in : 1'b0) : oq);
    if (par_mode) etest = 1'b0;
    else case (test_sel)
      2'd1: etest = ser_din;
      2'd2: etest = efb;
      2'd3: etest = eout;
      default: etest = 1'b0;
    endcase
    chk("fb_out", fb_out, efb);
    chk("out0_p", out0_p, eout);
    chk("out0_n", out0_n, ~eout);
    chk("out1_p R7", out1_p, eout);
    chk("out1_n R7", out1_n, ~eout);
    chk("test_out", test_out, etest);
  endtask

  task automatic model_step();
    bit tick;
    if (mr) begin
      fc = 0; fmv = eff_m(int'(m_val)); fq = (fmv / 2) != 0;
      oc = 0; ocd = int'(n_code); oq = (ocd != 0);
    end else begin
      if (fc == fmv - 1) begin fc = 0; fmv = eff_m(int'(m_val)); end
      else fc++;
      fq = fc < fmv / 2;
      tick = bypass ? (ref_in && rprev == 0) : 1'b1;
      if (tick) begin
        if (oc == (1 << ocd) - 1) begin oc = 0; ocd = int'(n_code); end
        else oc++;
        oq = oc < (1 << ocd) / 2;
      end
    end
    rprev = int'(ref_in);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      #(T/2 - 1);
      compare();
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic run_ref(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      if (i % half == 0) ref_in = ~ref_in;
      run(1);
    end
  endtask

  initial begin
    #(T * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    req = "R6"; test_sel = 2'd3;
    run(3);
    mr = 1'b0;
    run(2);
    req = "R1"; test_sel = 2'd2;
    run(40);
    req = "R4"; m_val = 9'd12;
    run(2);
    m_val = 9'd3;
    run(30);
    req = "R2"; m_val = 9'd0;
    run(12);
    m_val = 9'd1;
    run(6);
    m_val = 9'd6;
    run(14);
    req = "R3"; test_sel = 2'd3;
    for (int c = 0; c < 4; c++) begin
      n_code = 2'(c);
      run(36);
    end
    req = "R5"; n_code = 2'd3;
    run(9);
    n_code = 2'd1;
    run(3);
    n_code = 2'd2;
    run(24);
    req = "R8"; ser_din = 1'b1;
    for (int s = 0; s < 4; s++) begin
      test_sel = 2'(s);
      run(5);
      ser_din = ~ser_din;
      run(5);
    end
    req = "R9"; par_mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      test_sel = 2'(s);
      ser_din = 1'b1;
      run(6);
    end
    par_mode = 1'b0; test_sel = 2'd3;
    req = "R10"; bypass = 1'b1; n_code = 2'd1;
    run_ref(60, 3);
    n_code = 2'd0;
    run_ref(30, 3);
    n_code = 2'd2;
    run_ref(60, 4);
    bypass = 1'b0;
    run(20);
    req = "R6"; mr = 1'b1; m_val = 9'd7; n_code = 2'd3;
    run(4);
    mr = 1'b0;
    run(30);
    req = "R7"; m_val = 9'd9; n_code = 2'd1;
    run(30);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule